// File: doc/BRIEF.md
# Block and Permanent Lock-Bit Manager

This block is the write-protection controller of a multi-block flash device. It keeps one lock flag per erase block and one device-wide permanent lock flag. Software sets these flags with two-write command sequences: a setup write followed by a confirm write. After the confirm, a timed lock-set operation runs. During that time the ready/busy output is low and the ready bit of the status byte reads 0. Lock flags are only ever set here; clearing them and the array contents are handled elsewhere.

Protection works on two levels. For every program or erase request, the block's lock flag and the write-protect pin together decide whether the request is granted or denied. The permanent lock works one level up: it freezes the block lock flags. It also makes locked blocks untouchable even when the write-protect pin is high. A rejected request or sequence sets a sticky error bit in the status byte, and a clear-status command removes the error bits.

Top module: `lock_bit_mgr`

## Requirements
- R1: After reset, all block lock flags and the permanent lock are clear, `ready` is 1, `status` reads 80h, and neither `pe_grant` nor `pe_deny` is asserted.
- R2: A write of 60h followed by a write of 01h sets the lock flag of the block given on `cmd_blk` with the second write. The flag takes effect in the cycle in which `ready` returns high.
- R3: A write of 60h followed by a write of F1h sets the permanent lock, whatever the value on `cmd_blk`. The permanent lock stays set until reset.
- R4: After an accepted confirm, `ready` is 0 and status bit 7 is 0 for exactly LOCK_CYCLES cycles. Command writes made in that time have no effect.
- R5: If a setup write is followed by any byte other than 01h or F1h, the sequence is abandoned and status bit 5 (sequence error) is set. No lock flag changes and no busy period starts.
- R6: While the permanent lock is set, both confirm bytes are rejected. Status bit 4 (lock error) is set, no busy period starts, and no lock flag changes.
- R7: A request on `pe_req` gets a result one cycle later. A block that is locked, with `wp_n` low, gets `pe_deny`, and status bit 1 (protect error) is set. An unlocked block gets `pe_grant`.
- R8: With `wp_n` high, a program/erase request to a locked block is granted as long as the permanent lock is clear.
- R9: With the permanent lock set, a request to a locked block is denied whatever the level of `wp_n`. Unlocked blocks are still granted.
- R10: A write of 50h outside a sequence and outside a busy period clears status bits 5, 4 and 1. In the same position, 01h and F1h are ignored.
- R11: `pe_grant` and `pe_deny` are never high together, and each is high only in the cycle after a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command byte |
| cmd_blk | input | BLK_W | Block index supplied with the command write |
| wp_n | input | 1 | Write-protect pin; low enforces block locks |
| pe_req | input | 1 | Program/erase permission request |
| pe_blk | input | BLK_W | Block targeted by the request |
| pe_grant | output | 1 | Request allowed (one-cycle pulse) |
| pe_deny | output | 1 | Request refused (one-cycle pulse) |
| ready | output | 1 | High when no lock-set operation is running |
| status | output | 8 | Status byte: bit 7 ready, bit 5 sequence error, bit 4 lock error, bit 1 protect error |

## Verification
Program/erase requests are sent to random blocks with random write-protect levels, both before and after random block locks. This separates the plain per-block gate from the write-protect override. Random bad second bytes, and sequences sent after the permanent lock is set, check that rejection changes no flag: later requests to the targeted blocks still give the old answer. Directed cases count the exact busy length and inject a setup byte during busy, which shows that busy-time writes are dropped. A final phase repeats random requests under the permanent lock, which shows that it overrides a high write-protect pin.

// File: rtl/lockmgr_pkg.sv
`timescale 1ns/1ps
// Shared command codes, status bit positions and sequencer states for the
// lock-bit manager. Assumes 8-bit command bytes.
package lockmgr_pkg;
    localparam logic [7:0] CMD_SETUP     = 8'h60;
    localparam logic [7:0] CMD_CONF_BLK  = 8'h01;
    localparam logic [7:0] CMD_CONF_PERM = 8'hF1;
    localparam logic [7:0] CMD_CLR_STAT  = 8'h50;

    localparam int SR_READY    = 7;
    localparam int SR_SEQ_ERR  = 5;
    localparam int SR_LOCK_ERR = 4;
    localparam int SR_PROT_ERR = 1;

    typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_BUSY} seq_state_t;
endpackage

// File: rtl/lock_seq.sv
`timescale 1ns/1ps
// Command sequencer: decodes setup/confirm pairs, refuses lock changes while
// the permanent lock is set, and times the lock-set operation.
// Assumes one command write per cycle at most; writes during busy are dropped.
module lock_seq
    import lockmgr_pkg::*;
#(
    parameter int BLK_W       = 4,
    parameter int LOCK_CYCLES = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_data,
    input  logic [BLK_W-1:0] cmd_blk,
    input  logic             perm_lock,
    output logic             busy,
    output logic             set_blk_stb,
    output logic             set_perm_stb,
    output logic [BLK_W-1:0] tgt_blk,
    output logic             seq_err_stb,
    output logic             lock_err_stb,
    output logic             clr_stb
);
    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

    seq_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             is_perm_q;
    logic             start_blk, start_perm;

    // Decode the current write against the sequencer state.
    always_comb begin
        seq_err_stb  = 1'b0;
        lock_err_stb = 1'b0;
        clr_stb      = 1'b0;
        start_blk    = 1'b0;
        start_perm   = 1'b0;
        if (cmd_valid) begin
            case (state_q)
                ST_IDLE:  clr_stb = (cmd_data == CMD_CLR_STAT);
                ST_SETUP: begin
                    if (cmd_data == CMD_CONF_BLK || cmd_data == CMD_CONF_PERM) begin
                        if (perm_lock) lock_err_stb = 1'b1;
                        else if (cmd_data == CMD_CONF_BLK) start_blk = 1'b1;
                        else start_perm = 1'b1;
                    end else begin
                        seq_err_stb = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // State, target and busy timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            is_perm_q <= 1'b0;
            tgt_blk   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (cmd_valid && cmd_data == CMD_SETUP) state_q <= ST_SETUP;
                ST_SETUP: if (cmd_valid) begin
                    if (start_blk || start_perm) begin
                        state_q   <= ST_BUSY;
                        cnt_q     <= CNT_W'(LOCK_CYCLES - 1);
                        is_perm_q <= start_perm;
                        tgt_blk   <= cmd_blk;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_BUSY: begin
                    if (cnt_q == '0) state_q <= ST_IDLE;
                    else cnt_q <= cnt_q - 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Commit strobes fire in the final busy cycle.
    always_comb begin
        busy         = (state_q == ST_BUSY);
        set_blk_stb  = busy && (cnt_q == '0) && !is_perm_q;
        set_perm_stb = busy && (cnt_q == '0) && is_perm_q;
    end

    p_reject_no_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETUP && cmd_valid && perm_lock) |=> (state_q == ST_IDLE));
    p_busy_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && cnt_q != '0) |=> (state_q == ST_BUSY));
endmodule

// File: rtl/lock_store.sv
`timescale 1ns/1ps
// Lock flag storage: one set-only flag per block plus the permanent flag.
// Assumes the sequencer never raises both commit strobes together.
module lock_store #(
    parameter int NUM_BLOCKS = 16,
    parameter int BLK_W      = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_blk_stb,
    input  logic                  set_perm_stb,
    input  logic [BLK_W-1:0]      tgt_blk,
    output logic [NUM_BLOCKS-1:0] blk_lock,
    output logic                  perm_lock
);
    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
        // Per-block flag, set when its index is committed.
        always_ff @(posedge clk) begin
            if (!rst_n) blk_lock[b] <= 1'b0;
            else if (set_blk_stb && tgt_blk == BLK_W'(b)) blk_lock[b] <= 1'b1;
        end
    end

    // Device-wide permanent flag.
    always_ff @(posedge clk) begin
        if (!rst_n) perm_lock <= 1'b0;
        else if (set_perm_stb) perm_lock <= 1'b1;
    end

    p_perm_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        perm_lock |=> perm_lock);
    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        perm_lock |=> $stable(blk_lock));
endmodule

// File: rtl/prot_gate.sv
`timescale 1ns/1ps
// Program/erase gate: a locked block is refused when write-protect is low or
// the permanent lock is set. Result is registered one cycle after the request.
// Assumes pe_blk < NUM_BLOCKS; out-of-range indices read as unlocked.
module prot_gate #(
    parameter int NUM_BLOCKS = 16,
    parameter int BLK_W      = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pe_req,
    input  logic [BLK_W-1:0]      pe_blk,
    input  logic                  wp_n,
    input  logic [NUM_BLOCKS-1:0] blk_lock,
    input  logic                  perm_lock,
    output logic                  reject_now,
    output logic                  pe_grant,
    output logic                  pe_deny
);
    logic sel_locked;

    // Look up the target block's flag and decide.
    always_comb begin
        sel_locked = 1'b0;
        for (int i = 0; i < NUM_BLOCKS; i++)
            if (pe_blk == BLK_W'(i)) sel_locked = blk_lock[i];
        reject_now = pe_req && sel_locked && (!wp_n || perm_lock);
    end

    // Register the verdict as one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pe_grant <= 1'b0;
            pe_deny  <= 1'b0;
        end else begin
            pe_grant <= pe_req && !reject_now;
            pe_deny  <= reject_now;
        end
    end

    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(pe_grant && pe_deny));
    p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_grant || pe_deny) |-> $past(pe_req));
endmodule

// File: rtl/lock_bit_mgr.sv
`timescale 1ns/1ps
// Top of the lock-bit manager: ties sequencer, flag storage and gate together
// and keeps the sticky status error bits. Set strobes win over a clear.
module lock_bit_mgr
    import lockmgr_pkg::*;
#(
    parameter int NUM_BLOCKS  = 16,
    parameter int LOCK_CYCLES = 12,
    parameter int BLK_W       = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_data,
    input  logic [BLK_W-1:0] cmd_blk,
    input  logic             wp_n,
    input  logic             pe_req,
    input  logic [BLK_W-1:0] pe_blk,
    output logic             pe_grant,
    output logic             pe_deny,
    output logic             ready,
    output logic [7:0]       status
);
    logic                  busy, set_blk_stb, set_perm_stb;
    logic                  seq_err_stb, lock_err_stb, clr_stb, reject_now;
    logic [BLK_W-1:0]      tgt_blk;
    logic [NUM_BLOCKS-1:0] blk_lock;
    logic                  perm_lock;
    logic                  seq_err_q, lock_err_q, prot_err_q;

    lock_seq #(.BLK_W(BLK_W), .LOCK_CYCLES(LOCK_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .cmd_blk(cmd_blk), .perm_lock(perm_lock), .busy(busy),
        .set_blk_stb(set_blk_stb), .set_perm_stb(set_perm_stb), .tgt_blk(tgt_blk),
        .seq_err_stb(seq_err_stb), .lock_err_stb(lock_err_stb), .clr_stb(clr_stb)
    );

    lock_store #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_store (
        .clk(clk), .rst_n(rst_n), .set_blk_stb(set_blk_stb),
        .set_perm_stb(set_perm_stb), .tgt_blk(tgt_blk),
        .blk_lock(blk_lock), .perm_lock(perm_lock)
    );

    prot_gate #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .pe_req(pe_req), .pe_blk(pe_blk), .wp_n(wp_n),
        .blk_lock(blk_lock), .perm_lock(perm_lock), .reject_now(reject_now),
        .pe_grant(pe_grant), .pe_deny(pe_deny)
    );

    // Sticky error bits: cleared by the clear command, set by reject strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_err_q  <= 1'b0;
            lock_err_q <= 1'b0;
            prot_err_q <= 1'b0;
        end else begin
            if (clr_stb) begin
                seq_err_q  <= 1'b0;
                lock_err_q <= 1'b0;
                prot_err_q <= 1'b0;
            end
            if (seq_err_stb)  seq_err_q  <= 1'b1;
            if (lock_err_stb) lock_err_q <= 1'b1;
            if (reject_now)   prot_err_q <= 1'b1;
        end
    end

    // Assemble ready and the status byte.
    always_comb begin
        ready               = !busy;
        status              = '0;
        status[SR_READY]    = !busy;
        status[SR_SEQ_ERR]  = seq_err_q;
        status[SR_LOCK_ERR] = lock_err_q;
        status[SR_PROT_ERR] = prot_err_q;
    end

    p_deny_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pe_deny |-> status[SR_PROT_ERR]);
    p_busy_from_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(cmd_valid));
endmodule

// File: tb/lock_bit_mgr_test.sv
`timescale 1ns/1ps
module lock_bit_mgr_test;
    localparam int NB = 16;
    localparam int LC = 12;
    localparam int BW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_data = '0;
    logic [BW-1:0] cmd_blk = '0;
    logic          wp_n = 1'b0;
    logic          pe_req = 1'b0;
    logic [BW-1:0] pe_blk = '0;
    logic          pe_grant, pe_deny, ready;
    logic [7:0]    status;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit m_lock [NB];
    bit m_perm = 0;
    bit m_seq = 0, m_lck = 0, m_prot = 0;

    lock_bit_mgr #(.NUM_BLOCKS(NB), .LOCK_CYCLES(LC)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .cmd_blk(cmd_blk), .wp_n(wp_n), .pe_req(pe_req), .pe_blk(pe_blk),
        .pe_grant(pe_grant), .pe_deny(pe_deny), .ready(ready), .status(status)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] exp_status();
        return {1'b1, 1'b0, m_seq, m_lck, 2'b00, m_prot, 1'b0};
    endfunction

    function automatic bit exp_deny(int b, bit wp);
        return m_lock[b] && (!wp || m_perm);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_cmd(logic [7:0] d, logic [BW-1:0] b);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_data = d; cmd_blk = b;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Full confirm sequence; counts busy cycles, optionally injects a setup byte.
    task automatic lock_seq_run(bit perm, int b, bit inject);
        int busy_n = 0;
        write_cmd(8'h60, BW'(b));
        write_cmd(perm ? 8'hF1 : 8'h01, BW'(b));
        if (m_perm) begin
            m_lck = 1;
            check("R6 ready stays high", ready, 1'b1);
        end else begin
            while (ready == 1'b0 && busy_n < 4 * LC) begin
                busy_n++;
                if (status[7] !== 1'b0) check("R4 status bit7 in busy", status[7], 1'b0);
                cmd_valid = (inject && busy_n == 1);
                cmd_data  = 8'h60;
                @(negedge clk);
            end
            cmd_valid = 1'b0;
            check("R4 busy length", busy_n, LC);
            if (perm) m_perm = 1; else m_lock[b] = 1;
        end
        check(perm ? "R3 status after perm seq" : "R2 status after block seq",
              status, exp_status());
    endtask

    task automatic pe_try(int b, bit wp, string req);
        bit d;
        @(negedge clk);
        pe_req = 1'b1; pe_blk = BW'(b); wp_n = wp;
        @(negedge clk);
        pe_req = 1'b0;
        d = exp_deny(b, wp);
        if (d) m_prot = 1;
        check(req, {pe_grant, pe_deny}, {!d, d});
        check({req, " status"}, status, exp_status());
        @(negedge clk);
        check("R11 pulse ends", {pe_grant, pe_deny}, 2'b00);
    endtask

    initial begin
        int b;
        void'($urandom(32'd20240611));
        foreach (m_lock[i]) m_lock[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset status", status, 8'h80);
        check("R1 reset ready", ready, 1'b1);
        check("R1 reset pulses", {pe_grant, pe_deny}, 2'b00);
        pe_try(3, 0, "R1 reset unlocked");

        // Directed corner cases.
        lock_seq_run(0, 3, 0);
        pe_try(3, 0, "R7 locked wp low denied");
        pe_try(4, 0, "R7 neighbour granted");
        pe_try(3, 1, "R8 wp high overrides");
        write_cmd(8'h50, '0); m_seq = 0; m_lck = 0; m_prot = 0;
        check("R10 clear status", status, exp_status());
        write_cmd(8'h01, 4'd5);
        write_cmd(8'hF1, 4'd5);
        check("R10 stray confirms ignored", {ready, status}, {1'b1, exp_status()});
        pe_try(5, 0, "R10 stray confirm no lock");
        write_cmd(8'h60, 4'd6); write_cmd(8'h22, 4'd6); m_seq = 1;
        check("R5 bad confirm", {ready, status}, {1'b1, exp_status()});
        pe_try(6, 0, "R5 no lock after abort");
        lock_seq_run(0, 9, 1);
        check("R4 write in busy dropped", status, exp_status());
        pe_try(9, 0, "R2 block 9 locked");

        // Random phase before the permanent lock.
        for (int n = 0; n < 250; n++) begin
            int op = $urandom_range(0, 9);
            b = $urandom_range(0, NB - 1);
            if (op < 5) pe_try(b, 1'($urandom_range(0, 1)), "R7 random request");
            else if (op < 7) lock_seq_run(0, b, 0);
            else if (op < 9) begin
                logic [7:0] d;
                do d = 8'($urandom_range(0, 255)); while (d == 8'h01 || d == 8'hF1);
                write_cmd(8'h60, BW'(b)); write_cmd(d, BW'(b)); m_seq = 1;
                check("R5 random bad confirm", status, exp_status());
            end else begin
                write_cmd(8'h50, '0); m_seq = 0; m_lck = 0; m_prot = 0;
                check("R10 random clear", status, exp_status());
            end
        end

        // Permanent lock and its effects.
        lock_seq_run(1, 0, 0);
        b = 0;
        while (m_lock[b] && b < NB - 1) b++;
        lock_seq_run(0, b, 0);
        pe_try(b, 0, "R6 rejected block stays unlocked");
        lock_seq_run(1, 7, 0);
        pe_try(3, 1, "R9 perm beats wp high");
        for (int n = 0; n < 60; n++)
            pe_try($urandom_range(0, NB - 1), 1'($urandom_range(0, 1)), "R9 random under perm");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule